// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus: a clock line and an open-drain data line. Behind it sits a 32-row by 16-bit nonvolatile array, modelled as registers. A master opens each transfer with a START condition and sends a control byte. That byte selects a row, a byte order and a transfer direction. The slave then copies the whole row into a 16-bit buffer. Writes fill the buffer one or two bytes at a time and store it back through a timed erase and write cycle. Reads stream bytes out of the buffer and step the row address up or down. The address wraps at the ends of the array.

Both bus lines pass through two-flop synchronisers clocked by a faster system clock. The controller never drives the data line high. It only asserts `sda_oe_o`, which pulls the line low. While a programming cycle runs, the slave refuses every control byte, so the master can poll for completion. Some control bytes select a special mode. The slave acknowledges them, reports them to a neighbouring block, and keeps the array closed until the next STOP.

The erase and write phase lengths are parameters counted in system clock cycles.

Top module: `tws_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high (START) begins a transfer. A rising data line while the clock is high (STOP) returns the slave to standby from any state, with `sda_oe_o` low and `spec_o` low.
- R2: The first byte after START is taken MSB first. Bits 7..3 are the row, bit 2 is C1, bit 1 is C0 and bit 0 is the direction (1 = read). An accepted control byte is acknowledged by pulling the data line low during the ninth clock.
- R3: An accepted control byte copies the addressed 16-bit row into the buffer, and reads return that word.
- R4: C1 = 1 transfers the high byte (bits 15..8) first. C1 = 0 transfers the low byte first. The rule applies to reads and writes.
- R5: On a sequential read, the row steps once both bytes have gone out and the master has acknowledged the second. It steps by +1 when C1 = 0 and by -1 when C1 = 1, wrapping modulo 32.
- R6: A master not-acknowledge ends a read. The data line then stays released until the next START or STOP.
- R7: The first write data byte starts an erase phase of ERASE_CYC cycles. Once that phase has ended and a STOP (or START) has been seen, a write phase of WRITE_CYC cycles stores the whole buffer into the row. A one-byte write leaves the other byte of the row unchanged.
- R8: A second write byte that completes after the erase phase has ended is acknowledged but discarded. A third data byte is not acknowledged.
- R9: From the first write data byte until the write phase ends, no control byte is acknowledged.
- R10: A control byte matching 11xxx111 is acknowledged. It raises `spec_o` and presents the byte on `spec_ctl_o` until STOP, and it leaves buffer and array untouched.
- R11: A control byte ending in 110 is not acknowledged and changes nothing.
- R12: A one-byte read ended by a master not-acknowledge and a STOP leaves the slave in clean standby, even when it was issued in the middle of another read. The next transfer then behaves normally.
- R13: After reset the data line is released, `spec_o` is low and every row reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| spec_o | output | 1 | Special-mode control byte active until STOP |
| spec_ctl_o | output | 8 | The special-mode control byte |

## Verification
The bench writes every row, alternating between the two byte orders. It then reads the whole array twice: once rising across the wrap from row 31 to row 0, and once falling across the wrap from row 0 to row 31. A design with a swapped byte order, a wrong step direction or a missing wrap returns the wrong word at a known row.

A second byte sent after the erase phase must leave the old byte in place. If the design stored it anyway, that row would read back wrong. A third byte must be refused, and so must the polls issued just after STOP; a design that acknowledged them would let writes overlap.

Special and reserved bytes are sent to confirm they leave the array untouched. The bench also aborts a read in the middle and checks that it recovers.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int ADDR_W = 5;
  localparam int ROWS   = 1 << ADDR_W;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ACK, ST_WDATA, ST_RDATA, ST_RACK, ST_SPEC, ST_WAIT
  } bus_st_e;

  typedef enum logic [1:0] {
    P_IDLE, P_ERASE, P_HOLD, P_WRITE
  } prog_st_e;

  function automatic logic is_special(logic [BYTE_W-1:0] b);
    return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
  endfunction

  function automatic logic is_reserved(logic [BYTE_W-1:0] b);
    return b[2:0] == 3'b110;
  endfunction
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic ff1_q, ff2_q, ff3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= RST_VAL;
      ff2_q <= RST_VAL;
      ff3_q <= RST_VAL;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
      ff3_q <= ff2_q;
    end
  end

  assign q_o    = ff2_q;
  assign rise_o = ff2_q & ~ff3_q;
  assign fall_o = ~ff2_q & ff3_q;
endmodule

// File: rtl/tws_array.sv
module tws_array
  import tws_pkg::*;
#(
  parameter int ERASE_CYC = 2000000,
  parameter int WRITE_CYC = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_row_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              erase_start_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] wr_row_i,
  input  logic [WORD_W-1:0] wr_word_i,
  output logic              busy_o,
  output logic              erase_on_o
);
  localparam int MAX_CYC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  prog_st_e          st_q;
  logic [CW-1:0]     cnt_q;
  logic              pend_q;
  logic [ADDR_W-1:0] row_q;
  logic [WORD_W-1:0] word_q;
  logic              store;
  logic [WORD_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= P_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
      word_q <= '0;
    end else begin
      if (commit_i && st_q != P_IDLE) begin
        row_q  <= wr_row_i;
        word_q <= wr_word_i;
      end
      unique case (st_q)
        P_IDLE: if (erase_start_i) begin
          st_q   <= P_ERASE;
          cnt_q  <= CW'(ERASE_CYC - 1);
          pend_q <= 1'b0;
        end
        P_ERASE: begin
          if (commit_i) pend_q <= 1'b1;
          if (cnt_q == '0) begin
            if (pend_q || commit_i) begin
              st_q  <= P_WRITE;
              cnt_q <= CW'(WRITE_CYC - 1);
            end else begin
              st_q <= P_HOLD;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        P_HOLD: if (commit_i) begin
          st_q  <= P_WRITE;
          cnt_q <= CW'(WRITE_CYC - 1);
        end
        P_WRITE: begin
          if (cnt_q == '0) st_q <= P_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign store = (st_q == P_WRITE) && (cnt_q == '0);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[r] <= '0;
      else if (store && row_q == ADDR_W'(r)) mem_q[r] <= word_q;
    end
  end

  assign rd_word_o  = mem_q[rd_row_i];
  assign busy_o     = st_q != P_IDLE;
  assign erase_on_o = st_q == P_ERASE;

  AST_BUSY_ENDS_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(st_q) == P_WRITE); // R7
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_CYC)); // R7
  AST_WRITE_NEEDS_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == P_WRITE) |-> $past(st_q) inside {P_ERASE, P_HOLD}); // R7
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic              erase_on_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [WORD_W-1:0] buf_o,
  output logic              erase_start_o,
  output logic              commit_o,
  output logic              sda_oe_o,
  output logic              spec_o,
  output logic [BYTE_W-1:0] spec_ctl_o
);
  bus_st_e           st_q, nxt_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, spec_ctl_q;
  logic [ADDR_W-1:0] row_q, row_step;
  logic [WORD_W-1:0] buf_q;
  logic              hi_q, bidx_q, armed_q, reload_q, oe_q, spec_q, got_ack_q;
  logic              erase_start_q, commit_q;
  logic              byte_done;
  logic [BYTE_W-1:0] cur_byte, nxt_byte;

  assign byte_done = scl_fall_i && (cnt_q == 4'd8);
  assign cur_byte  = (hi_q ^ bidx_q) ? buf_q[15:8] : buf_q[7:0];
  assign nxt_byte  = (hi_q ^ ~bidx_q) ? buf_q[15:8] : buf_q[7:0];
  assign row_step  = hi_q ? row_q - 1'b1 : row_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      nxt_q         <= ST_IDLE;
      cnt_q         <= '0;
      sh_q          <= '0;
      spec_ctl_q    <= '0;
      row_q         <= '0;
      buf_q         <= '0;
      hi_q          <= 1'b0;
      bidx_q        <= 1'b0;
      armed_q       <= 1'b0;
      reload_q      <= 1'b0;
      oe_q          <= 1'b0;
      spec_q        <= 1'b0;
      got_ack_q     <= 1'b0;
      erase_start_q <= 1'b0;
      commit_q      <= 1'b0;
    end else begin
      erase_start_q <= 1'b0;
      commit_q      <= 1'b0;
      reload_q      <= 1'b0;
      if (reload_q) buf_q <= rd_word_i;
      if (start_i || stop_i) begin
        commit_q  <= armed_q;
        armed_q   <= 1'b0;
        st_q      <= start_i ? ST_CTRL : ST_IDLE;
        cnt_q     <= '0;
        oe_q      <= 1'b0;
        spec_q    <= 1'b0;
        got_ack_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_CTRL: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_done) begin
              cnt_q <= '0;
              if (busy_i || is_reserved(sh_q)) begin
                st_q <= ST_WAIT;
              end else if (is_special(sh_q)) begin
                spec_q     <= 1'b1;
                spec_ctl_q <= sh_q;
                oe_q       <= 1'b1;
                nxt_q      <= ST_SPEC;
                st_q       <= ST_ACK;
              end else begin
                row_q    <= sh_q[7:3];
                hi_q     <= sh_q[2];
                bidx_q   <= 1'b0;
                reload_q <= 1'b1;
                oe_q     <= 1'b1;
                nxt_q    <= sh_q[0] ? ST_RDATA : ST_WDATA;
                st_q     <= ST_ACK;
              end
            end
          end
          ST_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            st_q  <= nxt_q;
            if (nxt_q == ST_RDATA) begin
              sh_q <= cur_byte;
              oe_q <= ~cur_byte[7];
            end else begin
              oe_q <= 1'b0;
            end
          end
          ST_WDATA: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_done) begin
              cnt_q <= '0;
              oe_q  <= 1'b1;
              st_q  <= ST_ACK;
              if (!bidx_q || erase_on_i) begin
                if (hi_q ^ bidx_q) buf_q[15:8] <= sh_q;
                else buf_q[7:0] <= sh_q;
              end
              if (!bidx_q) begin
                erase_start_q <= 1'b1;
                armed_q       <= 1'b1;
                bidx_q        <= 1'b1;
                nxt_q         <= ST_WDATA;
              end else begin
                nxt_q <= ST_WAIT;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                oe_q  <= 1'b0;
                cnt_q <= '0;
                st_q  <= ST_RACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              if (sda_s_i) begin
                st_q <= ST_WAIT;
              end else begin
                got_ack_q <= 1'b1;
                if (bidx_q) begin
                  row_q    <= row_step;
                  reload_q <= 1'b1;
                end
              end
            end else if (scl_fall_i && got_ack_q) begin
              got_ack_q <= 1'b0;
              bidx_q    <= ~bidx_q;
              sh_q      <= nxt_byte;
              oe_q      <= ~nxt_byte[7];
              cnt_q     <= '0;
              st_q      <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign row_o         = row_q;
  assign buf_o         = buf_q;
  assign erase_start_o = erase_start_q;
  assign commit_o      = commit_q;
  assign sda_oe_o      = oe_q;
  assign spec_o        = spec_q;
  assign spec_ctl_o    = spec_ctl_q;

  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_WAIT) |-> !sda_oe_o); // R1
  AST_BUSY_NOACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CTRL && byte_done && busy_i && !start_i && !stop_i) |=> !sda_oe_o); // R9
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s_i); // R2
  AST_SPEC_NO_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_o |-> (!erase_start_o && !reload_q)); // R10
  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RACK && scl_rise_i && sda_s_i && !start_i && !stop_i) |=> !sda_oe_o); // R6
endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave
  import tws_pkg::*;
#(
  parameter int ERASE_CYC = 2000000,
  parameter int WRITE_CYC = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              spec_o,
  output logic [BYTE_W-1:0] spec_ctl_o
);
  logic scl_s, scl_rise, scl_fall, scl_high;
  logic sda_s, sda_rise, sda_fall;
  logic start, stop;
  logic busy, erase_on, erase_start, commit;
  logic [ADDR_W-1:0] row;
  logic [WORD_W-1:0] rd_word, buf_word;

  tws_sync #(.RST_VAL(1'b1)) u_scl_sync (
    .clk_i, .rst_ni, .d_i(scl_i), .q_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
  );
  tws_sync #(.RST_VAL(1'b1)) u_sda_sync (
    .clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  // both lines share latency, so clock-high is stable across a data edge
  assign scl_high = scl_s && !scl_rise;
  assign start    = scl_high && sda_fall;
  assign stop     = scl_high && sda_rise;

  tws_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_s_i(sda_s),
    .start_i(start), .stop_i(stop), .busy_i(busy), .erase_on_i(erase_on),
    .rd_word_i(rd_word), .row_o(row), .buf_o(buf_word),
    .erase_start_o(erase_start), .commit_o(commit),
    .sda_oe_o, .spec_o, .spec_ctl_o
  );

  tws_array #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_array (
    .clk_i, .rst_ni, .rd_row_i(row), .rd_word_o(rd_word),
    .erase_start_i(erase_start), .commit_i(commit),
    .wr_row_i(row), .wr_word_i(buf_word),
    .busy_o(busy), .erase_on_o(erase_on)
  );

  AST_STOP_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (!sda_oe_o && !spec_o)); // R1
  AST_ERASE_WHILE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start |-> !busy); // R9
endmodule

// File: tb/tws_eeprom_slave_tb.sv
`timescale 1ns/1ps
module tws_eeprom_slave_tb_top;
  localparam int HALF  = 8;
  localparam int ERASE = 300;
  localparam int WRITE = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic pull = 1'b0;
  logic sda_oe, spec;
  logic [7:0] spec_ctl;
  wire  sda_bus = ~(pull | sda_oe);

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] mdl [32];

  always #2.5 clk = ~clk;

  tws_eeprom_slave #(.ERASE_CYC(ERASE), .WRITE_CYC(WRITE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .spec_o(spec), .spec_ctl_o(spec_ctl)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    pull = 1'b0; tick(HALF/2);
    scl = 1'b1; tick(HALF);
    pull = 1'b1; tick(HALF);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(HALF/2); pull = 1'b1; tick(HALF/2);
    scl = 1'b1; tick(HALF);
    pull = 1'b0; tick(HALF);
  endtask

  task automatic send_bit(bit b);
    tick(HALF/2); pull = !b; tick(HALF/2);
    scl = 1'b1; tick(HALF);
    scl = 1'b0;
  endtask

  task automatic recv_bit(output bit b);
    pull = 1'b0; tick(HALF);
    scl = 1'b1; tick(HALF/2);
    b = sda_bus; tick(HALF/2);
    scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!ack);
  endtask

  function automatic logic [7:0] ctl(int row, bit hi, bit rd);
    return {row[4:0], hi, !hi, rd};
  endfunction

  task automatic wait_ready(bit expect_busy);
    bit ack;
    int n = 0;
    do begin
      bus_start();
      send_byte(8'h00, ack);
      bus_stop();
      if (n == 0 && expect_busy) chk(!ack, "R9 poll after stop", ack, 0);
      n++;
    end while (!ack && n < 40);
    chk(ack, "R9 ready after programming", ack, 1);
  endtask

  // n data bytes; gap cycles inserted before the second
  task automatic wr(int row, bit hi, int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                    int gap, output bit [2:0] acks);
    bit a;
    acks = '0;
    bus_start();
    send_byte(ctl(row, hi, 1'b0), a);
    chk(a, "R2 write control ack", a, 1);
    send_byte(b0, a); acks[0] = a;
    if (n > 1) begin tick(gap); send_byte(b1, a); acks[1] = a; end
    if (n > 2) begin send_byte(b2, a); acks[2] = a; end
    bus_stop();
  endtask

  task automatic rd_seq(int row, bit hi, int nw, string tag);
    bit a;
    logic [7:0] v, e;
    int r;
    bus_start();
    send_byte(ctl(row, hi, 1'b1), a);
    chk(a, "R2 read control ack", a, 1);
    for (int k = 0; k < nw; k++) begin
      r = hi ? ((row - k) & 31) : ((row + k) & 31);
      for (int j = 0; j < 2; j++) begin
        e = ((j == 0) == hi) ? mdl[r][15:8] : mdl[r][7:0];
        recv_byte(v, !(k == nw - 1 && j == 1));
        chk(v == e, tag, v, e);
      end
    end
    bus_stop();
  endtask

  initial begin
    bit [2:0] acks;
    bit a, b;
    logic [7:0] v;
    logic [15:0] w;
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R13 reset state
    chk(sda_oe == 1'b0, "R13 sda released", sda_oe, 0);
    chk(spec == 1'b0, "R13 spec low", spec, 0);
    rd_seq(0, 1'b0, 1, "R13 R3 row zero after reset");

    // R4 R7 sweep: every row, alternating order, two bytes
    for (int r = 0; r < 32; r++) begin
      bit hi = r[0];
      w = {8'(r * 37 + 5), 8'(r * 11 + 200)};
      wr(r, hi, 2, hi ? w[15:8] : w[7:0], hi ? w[7:0] : w[15:8], 8'h00, 0, acks);
      chk(acks[1:0] == 2'b11, "R7 data bytes acked", acks, 3);
      mdl[r] = w;
      wait_ready(1'b1);
    end

    // R5 increment across 31->0, R4 low first
    rd_seq(28, 1'b0, 32, "R5 R4 increment read");
    // R5 decrement across 0->31, R4 high first
    rd_seq(2, 1'b1, 32, "R5 R4 decrement read");

    // R7 single byte writes keep the other byte
    wr(7, 1'b0, 1, 8'hA5, 8'h00, 8'h00, 0, acks);
    mdl[7] = {mdl[7][15:8], 8'hA5};
    wait_ready(1'b1);
    wr(9, 1'b1, 1, 8'h3C, 8'h00, 8'h00, 0, acks);
    mdl[9] = {8'h3C, mdl[9][7:0]};
    wait_ready(1'b1);

    // R8 second byte after erase ended is acked, discarded
    wr(10, 1'b1, 2, 8'h11, 8'h22, 8'h00, ERASE + 100, acks);
    chk(acks[1], "R8 late byte acked", acks[1], 1);
    mdl[10] = {8'h11, mdl[10][7:0]};
    wait_ready(1'b1);

    // R8 third byte refused
    wr(11, 1'b0, 3, 8'h5A, 8'hC3, 8'h99, 0, acks);
    chk(acks == 3'b011, "R8 third byte nack", acks, 3);
    mdl[11] = {8'hC3, 8'h5A};
    wait_ready(1'b1);

    rd_seq(7, 1'b0, 1, "R7 row 7 low byte only");
    rd_seq(9, 1'b0, 1, "R7 row 9 high byte only");
    rd_seq(10, 1'b1, 1, "R8 row 10 late byte dropped");
    rd_seq(11, 1'b0, 1, "R8 row 11 two bytes");

    // R10 special mode
    bus_start();
    send_byte(8'hCF, a);
    chk(a, "R10 special acked", a, 1);
    tick(2);
    chk(spec == 1'b1, "R10 spec raised", spec, 1);
    chk(spec_ctl == 8'hCF, "R10 spec byte", spec_ctl, 8'hCF);
    for (int i = 0; i < 12; i++) send_bit(i[0]);
    chk(spec == 1'b1, "R10 spec held", spec, 1);
    bus_stop();
    tick(4);
    chk(spec == 1'b0, "R1 R10 spec cleared by stop", spec, 0);
    chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
    rd_seq(0, 1'b0, 2, "R10 array untouched");

    // R11 reserved byte
    bus_start();
    send_byte(8'h2E, a);
    chk(!a, "R11 reserved nack", a, 0);
    bus_stop();
    rd_seq(5, 1'b0, 1, "R11 array untouched");

    // R12 recovery from mid-read, R6 release after nack
    bus_start();
    send_byte(ctl(3, 1'b0, 1'b1), a);
    for (int i = 0; i < 3; i++) recv_bit(b);
    recv_byte(v, 1'b0);
    for (int i = 0; i < 3; i++) begin
      recv_bit(b);
      chk(b == 1'b1, "R6 line released after nack", b, 1);
    end
    bus_stop();
    tick(4);
    chk(sda_oe == 1'b0, "R12 standby after recovery", sda_oe, 0);
    rd_seq(3, 1'b1, 2, "R12 normal read after recovery");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule